// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits behind the write and read strobes of a parallel NOR flash bus and turns sequences of write cycles into operating-mode changes and word-program operations. Each write cycle carries an 11-bit word address and a 16-bit data word. The decoder tracks the two-cycle unlock prefix that guards most commands. It keeps the device in one of four modes: array read, identifier read, secured-region read, or fast-program (bypass). It also launches program operations on a small internal word array.

A program is modelled as a fixed busy window of `PROG_CYCLES` clocks. During that window the ready output is low, writes are discarded, and reads return a status word instead of data. At the end of the window the addressed word becomes the AND of its old value and the written data. In fast-program mode a program needs only a setup word and the address/data cycle. In that mode every command except fast-program and its two-cycle exit is dropped.

The bus has no back-pressure. Every write and read strobe is taken in the cycle it is presented. A read returns its word on `rd_data` one clock after `rd_en`, and `rd_data` holds that word until the next read.

Top module: `nor_cmd_decoder`

## Requirements
- R1: While `rst_n` is low and after it rises, the mode is array read, `ready` is 1, `rd_data` is 0 until the first read, and every array word reads 16'hFFFF.
- R2: The standard program sequence is AAh at 555h, then 55h at 2AAh, then A0h at 555h, then the address/data cycle. `ready` is then low for exactly `PROG_CYCLES` clocks, starting with the clock after the data write.
- R3: At the end of a program the addressed word (array index = low address bits) becomes old AND data. If the data has a 1 where the old word has a 0, status bit 5 reads 1 for that program; otherwise it reads 0.
- R4: While `ready` is low, a read returns a status word. Bit 7 is the complement of bit 7 of the data being programmed. Bit 6 is 0 on the first status read of a program and inverts on each later status read. Bit 5 is the error flag, and all other bits are 0.
- R5: Every write presented while `ready` is low is ignored, including unlock prefixes, commands and data for other words.
- R6: AAh at 555h, 55h at 2AAh, then 90h at 555h enters identifier mode. Any number of reads then return 16'h0001 for `rd_addr[1:0]`=0, 16'h22D3 for 1, and 0 otherwise. F0h at any address returns to array read.
- R7: AAh, 55h, then 88h (same addresses) enters secured mode. There, a read returns 16'hE500 + 16'h0111*i with i = `rd_addr[2:0]`. F0h has no effect in this mode. Only AAh at 555h, 55h at 2AAh, 90h at 555h, then 0000h at any address returns to array read.
- R8: AAh, 55h, then 20h enters fast-program mode. A0h at any address followed by the address/data cycle starts a program, and the mode stays fast-program afterwards. Reads in this mode return array data.
- R9: In fast-program mode, any idle-state write other than A0h or 90h is ignored. 90h followed by 0000h returns to array read; after that, a bare A0h plus data programs nothing.
- R10: A wrong address or data value inside an unlock prefix returns the decoder to its idle state without a mode change. Command words are full 16-bit values with the upper byte 0.
- R11: Driving `rst_n` low aborts a running program and leaves any mode. After release `ready` is 1, the mode is array read, and the array reads all-ones.
- R12: `rd_data` changes only in the clock after `rd_en`; mode changes without a read leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | 11 | Word address of the write |
| wr_data | input | 16 | Data word of the write |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 11 | Word address of the read |
| rd_data | output | 16 | Read result, valid the clock after `rd_en` |
| ready | output | 1 | 1 when idle, 0 during a program |

## Verification
A wrong internal state shows up at the ports no later than the next read or program. A corrupted unlock step makes the next read return array data where an identifier or secured word was expected, or the reverse, one clock after `rd_en`. A wrong busy counter changes the number of low `ready` clocks, and a wrong program latch changes the status bits 7, 6 and 5 read inside the window. A wrong AND merge shows in the word read back after `ready` rises.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_SECURE = 2'd2,
    MODE_BYPASS = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_UNL1 = 3'd1,
    ST_UNL2 = 3'd2,
    ST_PROG = 3'd3,
    ST_EXIT = 3'd4
  } step_e;

  localparam logic [15:0] CW_UNLOCK_A = 16'h00AA;
  localparam logic [15:0] CW_UNLOCK_B = 16'h0055;
  localparam logic [15:0] CW_IDENT    = 16'h0090;
  localparam logic [15:0] CW_PROG     = 16'h00A0;
  localparam logic [15:0] CW_SECURE   = 16'h0088;
  localparam logic [15:0] CW_BYPASS   = 16'h0020;
  localparam logic [15:0] CW_RESET    = 16'h00F0;
  localparam logic [15:0] CW_ZERO     = 16'h0000;

  function automatic logic [15:0] secure_word(input logic [2:0] idx);
    return 16'hE500 + 16'h0111 * {13'b0, idx};
  endfunction

endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              busy,
  output mode_e             mode,
  output logic              prog_start
);

  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(11'h555);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(11'h2AA);

  mode_e mode_q, mode_n;
  step_e step_q, step_n;
  logic  take, at_a, at_b;

  assign take = wr_en && !busy;
  assign at_a = (wr_addr == ADR_A);
  assign at_b = (wr_addr == ADR_B);

  always_comb begin
    mode_n     = mode_q;
    step_n     = step_q;
    prog_start = 1'b0;
    if (take) begin
      if (mode_q == MODE_BYPASS) begin
        case (step_q)
          ST_PROG: begin
            prog_start = 1'b1;
            step_n     = ST_IDLE;
          end
          ST_EXIT: begin
            step_n = ST_IDLE;
            if (wr_data == CW_ZERO) mode_n = MODE_ARRAY;
          end
          default: begin
            if (wr_data == CW_PROG)       step_n = ST_PROG;
            else if (wr_data == CW_IDENT) step_n = ST_EXIT;
          end
        endcase
      end else begin
        case (step_q)
          ST_IDLE: begin
            if (wr_data == CW_UNLOCK_A && at_a)
              step_n = ST_UNL1;
            else if (wr_data == CW_RESET && mode_q != MODE_SECURE)
              mode_n = MODE_ARRAY;
          end
          ST_UNL1: begin
            step_n = (wr_data == CW_UNLOCK_B && at_b) ? ST_UNL2 : ST_IDLE;
          end
          ST_UNL2: begin
            step_n = ST_IDLE;
            if (at_a) begin
              if (mode_q == MODE_SECURE) begin
                if (wr_data == CW_IDENT) step_n = ST_EXIT;
              end else if (mode_q == MODE_ARRAY) begin
                case (wr_data)
                  CW_IDENT:  mode_n = MODE_IDENT;
                  CW_PROG:   step_n = ST_PROG;
                  CW_SECURE: mode_n = MODE_SECURE;
                  CW_BYPASS: mode_n = MODE_BYPASS;
                  default:   step_n = ST_IDLE;
                endcase
              end
            end
          end
          ST_PROG: begin
            prog_start = 1'b1;
            step_n     = ST_IDLE;
          end
          default: begin
            step_n = ST_IDLE;
            if (wr_data == CW_ZERO) mode_n = MODE_ARRAY;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ARRAY;
      step_q <= ST_IDLE;
    end else begin
      mode_q <= mode_n;
      step_q <= step_n;
    end
  end

  assign mode = mode_q;

  // R9: in fast-program idle state, foreign commands leave state untouched
  assert_bypass_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_BYPASS && step_q == ST_IDLE && wr_en && !busy &&
     wr_data != CW_PROG && wr_data != CW_IDENT)
    |=> (mode_q == MODE_BYPASS && step_q == ST_IDLE));

  // R10: a broken second unlock cycle drops back to idle
  assert_bad_prefix_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_UNL1 && mode_q != MODE_BYPASS && wr_en && !busy &&
     !(wr_data == CW_UNLOCK_B && wr_addr == ADR_B))
    |=> (step_q == ST_IDLE && $stable(mode_q)));

endmodule

// File: rtl/nor_prog_engine.sv
module nor_prog_engine #(
  parameter int ADDR_W      = 11,
  parameter int WORDS       = 16,
  parameter int PROG_CYCLES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [15:0]              data,
  input  logic [$clog2(WORDS)-1:0] rd_idx,
  output logic [15:0]              rd_word,
  output logic                     busy,
  output logic                     pend_bit7,
  output logic                     err
);

  localparam int IDX_W = $clog2(WORDS);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES - 1);

  logic [15:0]      mem_q [WORDS];
  logic             busy_q, err_q, commit;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q, st_idx;
  logic [15:0]      data_q;

  assign st_idx = addr[IDX_W-1:0];
  assign commit = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_LOAD;
      idx_q  <= st_idx;
      data_q <= data;
      err_q  <= |(data & ~mem_q[st_idx]);
    end else if (busy_q) begin
      if (commit) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem_q[w] <= 16'hFFFF;
    end else if (commit) begin
      mem_q[idx_q] <= mem_q[idx_q] & data_q;
    end
  end

  assign rd_word   = mem_q[rd_idx];
  assign busy      = busy_q;
  assign pend_bit7 = data_q[7];
  assign err       = err_q;

  // R2: the busy window only opens on a decoded program start
  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start));

  // R3: a committed word never gains a 1 bit
  assert_and_merge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ((mem_q[$past(idx_q)] & ~$past(mem_q[idx_q])) == 16'h0));

endmodule

// File: rtl/nor_read_port.sv
module nor_read_port
  import nor_cmd_pkg::*;
#(
  parameter int          ADDR_W = 11,
  parameter logic [15:0] MFR_ID = 16'h0001,
  parameter logic [15:0] DEV_ID = 16'h22D3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  mode_e             mode,
  input  logic              busy,
  input  logic              start,
  input  logic [15:0]       arr_word,
  input  logic              pend_bit7,
  input  logic              err,
  output logic [15:0]       rd_data
);

  logic [15:0] rd_q, view, status, ident;
  logic        tog_q;

  always_comb begin
    status    = 16'h0000;
    status[7] = ~pend_bit7;
    status[6] = tog_q;
    status[5] = err;
  end

  always_comb begin
    case (rd_addr[1:0])
      2'd0:    ident = MFR_ID;
      2'd1:    ident = DEV_ID;
      default: ident = 16'h0000;
    endcase
  end

  always_comb begin
    if (busy) view = status;
    else begin
      case (mode)
        MODE_IDENT:  view = ident;
        MODE_SECURE: view = secure_word(rd_addr[2:0]);
        default:     view = arr_word;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 16'h0000;
      tog_q <= 1'b0;
    end else begin
      if (rd_en) rd_q <= view;
      if (start)              tog_q <= 1'b0;
      else if (busy && rd_en) tog_q <= ~tog_q;
    end
  end

  assign rd_data = rd_q;

  // R12: output only moves after a read strobe
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q));

  // R4: consecutive status reads alternate bit 6
  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en && !start && $past(busy && rd_en && !start)) |=>
      (rd_q[6] != $past(rd_q[6])));

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int          ADDR_W      = 11,
  parameter int          WORDS       = 16,
  parameter int          PROG_CYCLES = 8,
  parameter logic [15:0] MFR_ID      = 16'h0001,
  parameter logic [15:0] DEV_ID      = 16'h22D3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  output logic              ready
);

  localparam int IDX_W = $clog2(WORDS);

  mode_e       mode;
  logic        prog_start, busy, pend_bit7, err;
  logic [15:0] arr_word;

  nor_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .mode(mode), .prog_start(prog_start)
  );

  nor_prog_engine #(.ADDR_W(ADDR_W), .WORDS(WORDS), .PROG_CYCLES(PROG_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .addr(wr_addr),
    .data(wr_data), .rd_idx(rd_addr[IDX_W-1:0]), .rd_word(arr_word),
    .busy(busy), .pend_bit7(pend_bit7), .err(err)
  );

  nor_read_port #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .mode(mode), .busy(busy), .start(prog_start), .arr_word(arr_word),
    .pend_bit7(pend_bit7), .err(err), .rd_data(rd_data)
  );

  assign ready = ~busy;

  // R5: the decoder never launches a program inside a busy window
  assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !busy);

  // R5: writes during a program cannot move the mode
  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode));

  // R4: status bit 7 mirrors the inverted pending data bit
  assert_dq7_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> (rd_data[7] == !$past(pend_bit7)));

endmodule

// File: tb/nor_cmd_decoder_bench.sv
module nor_cmd_decoder_bench;

  localparam int P = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [10:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [10:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic        ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] model [16];

  always #5 clk = ~clk;

  nor_cmd_decoder #(.PROG_CYCLES(P)) u_nor_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .ready(ready)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, input logic [15:0] exp, input string tag);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    chk(tag, rd_data, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic unlock(input logic [15:0] cmd);
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0055);
    wr(11'h555, cmd);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) model[i] = 16'hFFFF;
  endtask

  function automatic logic [15:0] stat(input logic [15:0] d, input bit tog, input bit e);
    return (d[7] ? 16'h0000 : 16'h0080) | (tog ? 16'h0040 : 16'h0000) | (e ? 16'h0020 : 16'h0000);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] d, old;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    // R1: state during reset
    chk("R1 ready in reset", {15'b0, ready}, 16'h0001);
    do_reset();
    chk("R1 ready after reset", {15'b0, ready}, 16'h0001);
    chk("R1 rd_data before any read", rd_data, 16'h0000);
    for (int i = 0; i < 16; i++) rd(11'(i), 16'hFFFF, "R1 erased word");

    // R2: standard program and exact busy length
    unlock(16'h00A0);
    wr(11'd0, 16'hFFFE);
    model[0] = 16'hFFFE;
    wait_ready(n);
    chk("R2 busy clocks", 16'(n), 16'(P));
    rd(11'd0, model[0], "R2 programmed word");

    // R8: fast-program sweep across every word
    unlock(16'h0020);
    for (int i = 1; i < 16; i++) begin
      d = ~(16'h1 << i);
      wr(11'h123, 16'h00A0);
      wr(11'(i), d);
      model[i] = model[i] & d;
      wait_ready(n);
      chk("R8 fast busy clocks", 16'(n), 16'(P));
    end
    for (int i = 0; i < 16; i++) rd(11'(i), model[i], "R8 array read in fast mode");

    // R9: foreign commands in fast mode are dropped (a secure entry attempt)
    unlock(16'h0088);
    wr(11'h000, 16'h00F0);
    rd(11'd5, model[5], "R9 still array view in fast mode");
    wr(11'h000, 16'h00A0);
    wr(11'd3, 16'h00FF);
    model[3] = model[3] & 16'h00FF;
    wait_ready(n);
    rd(11'd3, model[3], "R9 fast program after ignored writes");
    wr(11'h000, 16'h0090);
    wr(11'h000, 16'h0000);
    wr(11'h555, 16'h00A0);
    wr(11'd2, 16'h0000);
    chk("R9 no program after exit", {15'b0, ready}, 16'h0001);
    rd(11'd2, model[2], "R9 word unchanged after exit");

    // R3/R4: status during a program that tries to raise bits
    old = model[4];
    d = 16'h1234;
    unlock(16'h00A0);
    wr(11'd4, d);
    rd(11'd4, stat(d, 1'b0, |(d & ~old)), "R4 first status read");
    rd(11'd4, stat(d, 1'b1, |(d & ~old)), "R4 second status read");
    rd(11'd9, stat(d, 1'b0, |(d & ~old)), "R4 third status read");
    wait_ready(n);
    model[4] = old & d;
    rd(11'd4, model[4], "R3 AND merge with error");

    // R3/R4: clean program, no error flag
    old = model[8];
    d = old & 16'hF07F;
    unlock(16'h00A0);
    wr(11'd8, d);
    rd(11'd8, stat(d, 1'b0, 1'b0), "R3 status without error");
    wait_ready(n);
    model[8] = old & d;
    rd(11'd8, model[8], "R3 AND merge clean");

    // R5: writes during busy are ignored
    unlock(16'h00A0);
    wr(11'd6, 16'hFF00);
    model[6] = model[6] & 16'hFF00;
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0055);
    wr(11'h555, 16'h0090);
    wr(11'd7, 16'h0000);
    wait_ready(n);
    rd(11'd6, model[6], "R5 still array mode after busy writes");
    rd(11'd7, model[7], "R5 busy data write dropped");

    // R6: identifier mode
    unlock(16'h0090);
    rd(11'd0, 16'h0001, "R6 id word 0");
    rd(11'd1, 16'h22D3, "R6 id word 1");
    rd(11'd2, 16'h0000, "R6 id word 2");
    rd(11'h010, 16'h0001, "R6 id repeated");
    wr(11'h3FF, 16'h00F0);
    chk("R12 rd_data held across mode change", rd_data, 16'h0001);
    rd(11'd0, model[0], "R6 back to array");

    // R10: broken prefixes
    wr(11'h555, 16'h00AA);
    wr(11'h2AB, 16'h0055);
    wr(11'h555, 16'h0090);
    rd(11'd0, model[0], "R10 wrong second address");
    wr(11'h554, 16'h00AA);
    wr(11'h2AA, 16'h0055);
    wr(11'h555, 16'h0090);
    rd(11'd0, model[0], "R10 wrong first address");
    wr(11'h555, 16'h01AA);
    wr(11'h2AA, 16'h0055);
    wr(11'h555, 16'h0090);
    rd(11'd0, model[0], "R10 upper byte set");

    // R7: secured mode
    unlock(16'h0088);
    for (int i = 0; i < 8; i++)
      rd(11'(i), 16'hE500 + 16'h0111 * 16'(i), "R7 secure word");
    wr(11'h000, 16'h00F0);
    rd(11'd1, 16'hE611, "R7 reset command ignored");
    unlock(16'h0090);
    wr(11'h000, 16'h0001);
    rd(11'd2, 16'hE722, "R7 bad exit stays secure");
    unlock(16'h0090);
    wr(11'h000, 16'h0000);
    rd(11'd2, model[2], "R7 exit to array");

    // R11: reset leaves secured mode
    unlock(16'h0088);
    do_reset();
    rd(11'd2, 16'hFFFF, "R11 array after reset from secure");

    // R11: reset aborts a running program
    unlock(16'h00A0);
    wr(11'd1, 16'h0000);
    chk("R11 busy before abort", {15'b0, ready}, 16'h0000);
    do_reset();
    chk("R11 ready after abort", {15'b0, ready}, 16'h0001);
    rd(11'd1, 16'hFFFF, "R11 aborted word");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule